// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block passes a data word between two ports, A and B, in either direction. Each direction has its own bank of storage latches and its own three active-low controls: a chip select, a capture control and a drive control. While the capture control is low the latches follow the source port, so the data passes straight through. When the capture control goes high they freeze the last value they took. The destination port drives the latch contents only while both the chip select and the drive control of that direction are low.

Tri-state ports are modelled as a data word plus one drive-enable bit per port. Each port also has a keeper register that remembers the last value seen on that port. The value can come from an external source or from the block's own driver. The latches always read the port through its keeper, so a port that nobody drives still presents a valid word.

Top module: `xcvr_latched_top`

## Requirements
- R1: While `rst_n` is low, `a_oe` and `b_oe` are 0. Reset clears both latch banks and both keepers to 0, so after reset a direction that is enabled with its capture control high drives 0.
- R2: When `ce_ab_n`=0 and `le_ab_n`=0, the A-to-B latches are transparent. With `oe_ab_n`=0, `b_out` equals the A-side view in the same cycle. At each rising clock edge in this state the latches store that view.
- R3: When `le_ab_n` is 1, the A-to-B latches hold the value stored at the last rising edge at which `ce_ab_n`=0 and `le_ab_n`=0, whatever the A-side data does.
- R4: While `ce_ab_n`=1, the A-to-B latches ignore `le_ab_n` and the A data and keep their contents.
- R5: `b_oe` is 1 exactly when `ce_ab_n`=0 and `oe_ab_n`=0 (out of reset), and `le_ab_n` has no effect on it. While `b_oe` is 1, `b_out` carries the A-to-B latch output.
- R6: The B-to-A direction follows R2 to R5 with `ce_ba_n`, `le_ba_n`, `oe_ba_n`, `b_in`, `a_out` and `a_oe` in place of their A-to-B counterparts.
- R7: Loading or driving one direction does not change the contents of the other direction's latches.
- R8: The A-side view is `a_in` while `a_ext_en`=1, and otherwise the A keeper value. At each clock edge the keeper takes `a_in` if `a_ext_en`=1. Otherwise it takes `a_out` if `a_oe`=1. Otherwise it holds. The B side is identical with `b_in`, `b_ext_en`, `b_out` and `b_oe`.
- R9: A value the block itself drives onto a port, with no external driver present, is kept by that port's keeper. It is then presented to the opposite direction's latches once the internal driver turns off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 8 | Data from the external driver on port A |
| a_ext_en | input | 1 | External driver active on port A |
| b_in | input | 8 | Data from the external driver on port B |
| b_ext_en | input | 1 | External driver active on port B |
| ce_ab_n | input | 1 | A-to-B chip select, active low |
| le_ab_n | input | 1 | A-to-B capture control, active low (low = transparent) |
| oe_ab_n | input | 1 | A-to-B drive control, active low |
| ce_ba_n | input | 1 | B-to-A chip select, active low |
| le_ba_n | input | 1 | B-to-A capture control, active low |
| oe_ba_n | input | 1 | B-to-A drive control, active low |
| a_out | output | 8 | Data the block drives on port A |
| a_oe | output | 1 | Block drives port A |
| b_out | output | 8 | Data the block drives on port B |
| b_oe | output | 1 | Block drives port B |

## Verification
The bench sweeps all eight control combinations of each direction and checks the drive enable against them. A design that lets the capture control or the wrong chip select reach the drive enable fails this sweep. All 256 data words are passed through each direction while it is transparent, which catches a swapped or stuck bit. The hold checks change the source data right after the capture control rises and while the chip select is high. A design that keeps loading in storage mode, or that honours the capture control while deselected, shows the new word instead of the stored one. The keeper checks float a port after an external value and after an internally driven value. A keeper that follows garbage on an undriven input, or that misses its own driver, hands the wrong word to the other direction.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        KEEP_HOLD = 2'd0,
        KEEP_EXT  = 2'd1,
        KEEP_INT  = 2'd2
    } keep_src_e;

    function automatic keep_src_e keep_pick(input logic ext_en, input logic int_en);
        if (ext_en)      return KEEP_EXT;
        else if (int_en) return KEEP_INT;
        else             return KEEP_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_keeper.sv
module xcvr_keeper
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ext_data,
    input  logic         ext_en,
    input  logic [W-1:0] int_data,
    input  logic         int_en,
    output logic [W-1:0] view
);

    typedef struct packed {
        logic [W-1:0] held;
    } keep_state_t;

    keep_state_t st_d, st_q;
    keep_src_e   src;

    always_comb begin
        st_d = st_q;
        src  = keep_pick(ext_en, int_en);
        case (src)
            KEEP_EXT: st_d.held = ext_data;
            KEEP_INT: st_d.held = int_data;
            default:  st_d.held = st_q.held;
        endcase
        view = ext_en ? ext_data : st_q.held;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_KEEP_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_en && !int_en) |=> $stable(st_q.held)); // R8

    AST_KEEP_TAKES_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        ext_en |=> (st_q.held == $past(ext_data))); // R8

    AST_KEEP_TAKES_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_en && int_en) |=> (st_q.held == $past(int_data))); // R9

endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce_n,
    input  logic         le_n,
    input  logic         oe_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         drive
);

    typedef struct packed {
        logic [W-1:0] stored;
    } dir_state_t;

    dir_state_t st_d, st_q;
    logic       open_gate;

    always_comb begin
        st_d      = st_q;
        open_gate = !ce_n && !le_n;
        if (open_gate) st_d.stored = din;
        dout  = open_gate ? din : st_q.stored;
        drive = rst_n && !ce_n && !oe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_DESELECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> $stable(st_q.stored)); // R4

    AST_STORE_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        le_n |=> $stable(st_q.stored)); // R3

    AST_OPEN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !le_n) |=> (st_q.stored == $past(din))); // R2

    AST_DRIVE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> (!ce_n && !oe_n)); // R5

endmodule

// File: rtl/xcvr_latched_top.sv
module xcvr_latched_top #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic         a_ext_en,
    input  logic [W-1:0] b_in,
    input  logic         b_ext_en,
    input  logic         ce_ab_n,
    input  logic         le_ab_n,
    input  logic         oe_ab_n,
    input  logic         ce_ba_n,
    input  logic         le_ba_n,
    input  logic         oe_ba_n,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    logic [W-1:0] a_view, b_view;

    xcvr_keeper #(.W(W)) u_keep_a (
        .clk(clk), .rst_n(rst_n),
        .ext_data(a_in), .ext_en(a_ext_en),
        .int_data(a_out), .int_en(a_oe),
        .view(a_view)
    );

    xcvr_keeper #(.W(W)) u_keep_b (
        .clk(clk), .rst_n(rst_n),
        .ext_data(b_in), .ext_en(b_ext_en),
        .int_data(b_out), .int_en(b_oe),
        .view(b_view)
    );

    xcvr_dir #(.W(W)) u_ab (
        .clk(clk), .rst_n(rst_n),
        .ce_n(ce_ab_n), .le_n(le_ab_n), .oe_n(oe_ab_n),
        .din(a_view), .dout(b_out), .drive(b_oe)
    );

    xcvr_dir #(.W(W)) u_ba (
        .clk(clk), .rst_n(rst_n),
        .ce_n(ce_ba_n), .le_n(le_ba_n), .oe_n(oe_ba_n),
        .din(b_view), .dout(a_out), .drive(a_oe)
    );

    always_comb begin
        if (!rst_n) begin
            AST_QUIET_IN_RESET: assert (!a_oe && !b_oe); // R1
        end
    end

    AST_BA_UNTOUCHED_BY_AB: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_ba_n && !ce_ab_n) |=> $stable(u_ba.st_q.stored)); // R7

endmodule

// File: tb/sim_xcvr_latched_top.sv
module sim_xcvr_latched_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a_in = '0, b_in = '0;
    logic       a_ext_en = 1'b0, b_ext_en = 1'b0;
    logic       ce_ab_n = 1'b1, le_ab_n = 1'b1, oe_ab_n = 1'b1;
    logic       ce_ba_n = 1'b1, le_ba_n = 1'b1, oe_ba_n = 1'b1;
    logic [7:0] a_out, b_out;
    logic       a_oe, b_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xcvr_latched_top u0 (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_ext_en(a_ext_en), .b_in(b_in), .b_ext_en(b_ext_en),
        .ce_ab_n(ce_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
        .ce_ba_n(ce_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    // bus contention monitor: block and external both driving a port
    always @(negedge clk) begin
        if (rst_n && ((a_oe && a_ext_en) || (b_oe && b_ext_en))) begin
            bad++;
            $display("FAIL contention actual=%b%b expected=00", a_oe && a_ext_en, b_oe && b_ext_en);
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset quiets drivers even with enables low
        ce_ab_n = 0; oe_ab_n = 0; ce_ba_n = 0; oe_ba_n = 0;
        settle();
        chk("R1 reset a_oe", {8'h0, a_oe}, 9'h0);
        chk("R1 reset b_oe", {8'h0, b_oe}, 9'h0);
        ce_ba_n = 1; oe_ba_n = 1; le_ab_n = 1;
        settle();
        rst_n = 1;
        settle();
        chk("R1 cleared AB contents", {b_oe, b_out}, 9'h100);

        // R5: control sweep A-to-B
        a_ext_en = 1; b_ext_en = 0; a_in = 8'h00;
        for (int c = 0; c < 8; c++) begin
            {ce_ab_n, le_ab_n, oe_ab_n} = c[2:0];
            settle();
            chk("R5 b_oe sweep", {8'h0, b_oe}, {8'h0, (c[2] == 0 && c[0] == 0)});
        end

        // R2: transparent sweep of every word
        ce_ab_n = 0; le_ab_n = 0; oe_ab_n = 0;
        for (int v = 0; v < 256; v++) begin
            a_in = v[7:0];
            settle();
            chk("R2 transparent", {b_oe, b_out}, {1'b1, v[7:0]});
        end

        // R3: capture then hold while A changes
        a_in = 8'h5A;
        settle();
        le_ab_n = 1; a_in = 8'hC3;
        settle();
        chk("R3 hold after capture", {b_oe, b_out}, 9'h15A);
        a_in = 8'h0F;
        settle();
        chk("R3 hold later", {b_oe, b_out}, 9'h15A);

        // R4: deselected, capture control low, A changes
        ce_ab_n = 1; le_ab_n = 0; a_in = 8'h11;
        settle();
        chk("R4 deselected no drive", {8'h0, b_oe}, 9'h0);
        a_in = 8'h22;
        settle();
        ce_ab_n = 0; le_ab_n = 1; oe_ab_n = 0;
        settle();
        chk("R4 contents kept", {b_oe, b_out}, 9'h15A);

        // R6: B-to-A control sweep and transparent sweep
        ce_ab_n = 1; a_ext_en = 0; b_ext_en = 1; b_in = 8'h00;
        for (int c = 0; c < 8; c++) begin
            {ce_ba_n, le_ba_n, oe_ba_n} = c[2:0];
            settle();
            chk("R6 a_oe sweep", {8'h0, a_oe}, {8'h0, (c[2] == 0 && c[0] == 0)});
        end
        ce_ba_n = 0; le_ba_n = 0; oe_ba_n = 0;
        for (int v = 255; v >= 0; v--) begin
            b_in = v[7:0];
            settle();
            chk("R6 transparent", {a_oe, a_out}, {1'b1, v[7:0]});
        end
        b_in = 8'hA5;
        settle();
        le_ba_n = 1; b_in = 8'h3C;
        settle();
        chk("R6 hold", {a_oe, a_out}, 9'h1A5);
        ce_ba_n = 1; le_ba_n = 0; b_in = 8'h44;
        settle();
        ce_ba_n = 0; le_ba_n = 1;
        settle();
        chk("R6 deselect keeps", {a_oe, a_out}, 9'h1A5);

        // R7: AB contents survived all B-to-A traffic
        ce_ba_n = 1; b_ext_en = 0;
        ce_ab_n = 0; le_ab_n = 1; oe_ab_n = 0;
        settle();
        chk("R7 AB untouched", {b_oe, b_out}, 9'h15A);

        // R8: keeper on A holds last external word when floated
        ce_ab_n = 1; a_ext_en = 1; a_in = 8'h77;
        settle();
        a_ext_en = 0; a_in = 8'hEE;
        settle();
        ce_ab_n = 0; le_ab_n = 0; oe_ab_n = 0;
        settle();
        chk("R8 keeper view", {b_oe, b_out}, 9'h177);
        settle();
        chk("R8 keeper steady", {b_oe, b_out}, 9'h177);

        // R9: block's own drive on A kept after driver turns off
        ce_ab_n = 1; le_ab_n = 1;
        b_ext_en = 1; b_in = 8'h3C;
        ce_ba_n = 0; le_ba_n = 0; oe_ba_n = 0;
        settle();
        chk("R9 BA drives A", {a_oe, a_out}, 9'h13C);
        ce_ba_n = 1; b_ext_en = 0; b_in = 8'h99;
        ce_ab_n = 0; le_ab_n = 0; oe_ab_n = 0;
        settle();
        chk("R9 own drive kept", {b_oe, b_out}, 9'h13C);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule